// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable model of a single-bank synchronous SRAM. It has registered inputs, a registered read path and a 36-bit word split into four 9-bit lanes (8 data bits plus parity each). Accesses start on one of two active-low address strobes. The processor strobe always opens an access as a read, and any write it carries lands on the following clock edge. The controller strobe can write on the edge that starts it. After the start, a two-bit wrapping burst counter moves the address inside an aligned group of four words. It steps on each edge that has the advance input low, in linear or interleaved order.

Read data leaves through an output register one edge after the address edge. Output drive is not a pad here: it is a separate `drive_en` port next to `rdata`. Drive is held off in five cases: output enable high, the first cycle after the part is selected from the deselected state, any write, a deselect, and sleep. A sleep input puts the model into a state that ignores all accesses and keeps the memory contents. It takes effect two edges after a change and releases two edges after a change.

Top module: `sram_pipe`

## Requirements
- R1: The part is selected when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. These three pins are sampled only on an edge where a strobe starts an access. During a continuing access they have no effect.
- R2: `cpu_n` is ignored while `ce1_n`=1. When `cpu_n` and `ctl_n` are both low on a recognised edge, the access is a processor-strobe access.
- R3: A processor-strobe start is a read whatever the write inputs and `adv_n` say. A write happens only on the next edge, at the started address when `adv_n`=1, if the write inputs are active there.
- R4: A controller-strobe start with active write inputs writes `wdata` to `addr` on that same edge, and `adv_n` is ignored on that edge.
- R5: Lane i is bits [9i+8:9i]. `gw_n`=0 writes all four lanes. Otherwise, when `bwe_n`=0, lane i is written when `bsel_n[i]`=0. Lanes that are not written keep their contents.
- R6: A read started or continued on edge N shows its word on `rdata` after edge N+1. `rdata` holds its value while no read result arrives.
- R7: On a continuing edge with `adv_n`=0, the low two address bits step to the next position of the burst. The burst starts at the loaded address `s` and its step `k` runs from 0 to 3. With `linear`=1 the low bits are (s+k) mod 4; with `linear`=0 they are s XOR k. The upper bits stay fixed.
- R8: `drive_en` is 0 whenever `oe_n`=1. It is also 0 after reset and during the first cycle after the edge that selects the part from the deselected state.
- R9: After an edge that writes, `drive_en` stays 0 until a strobe starts a new read and its data arrives.
- R10: An edge on which a strobe is recognised with the part not selected turns `drive_en` off from that edge on.
- R11: Two edges after `sleep` rises, the model ignores strobes and writes and holds `drive_en` at 0. It leaves that state two edges after `sleep` falls, still deselected with outputs off. Memory contents are kept throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of control state |
| addr | input | AW | Word address, loaded on a start edge |
| cpu_n | input | 1 | Processor address strobe, active low |
| ctl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| gw_n | input | 1 | Write all lanes, active low |
| bwe_n | input | 1 | Lane write enable, active low |
| bsel_n | input | 4 | Per-lane write selects, active low |
| oe_n | input | 1 | Output enable, active low, combinational |
| sleep | input | 1 | Sleep request, active high |
| linear | input | 1 | Burst order: 1 linear, 0 interleaved (static) |
| wdata | input | 36 | Write data |
| rdata | output | 36 | Registered read data |
| drive_en | output | 1 | Output drive enable for the read data |

## Verification
Some rules can be checked on every cycle, and the bound checker covers them. These are: output enable gating drive, write and deselect edges forcing drive off, sleep forcing drive off, drive only ever following a read two edges earlier, a processor-strobe start never writing, and a selected controller-strobe start with write inputs always writing. Other behaviour can only be shown by the bench's scenarios against its shadow memory. This covers lane-masked contents, strobe priority and the ignored processor strobe, second-edge write data, both burst orders with wraparound, the first-cycle mask, and memory surviving a write attempt made during sleep.

// File: rtl/sram_pkg.sv
package sram_pkg;

    localparam int LANES   = 4;
    localparam int LANE_W  = 9;
    localparam int WORD_W  = LANES * LANE_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LANES-1:0]  lane_mask_t;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef struct packed {
        op_e        op;
        lane_mask_t mask;
    } cmd_t;

    // Low two address bits of burst step k from start s.
    function automatic logic [1:0] burst_low(logic lin, logic [1:0] s, logic [1:0] k);
        return lin ? (s + k) : (s ^ k);
    endfunction

    // Lanes to write for the given active-low controls.
    function automatic lane_mask_t write_mask(logic gw_n, logic bwe_n, lane_mask_t sel_n);
        if (!gw_n)       return '1;
        else if (!bwe_n) return ~sel_n;
        else             return '0;
    endfunction

endpackage

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cpu_n,
    input  logic       ctl_n,
    input  logic       adv_n,
    input  logic       ce1_n,
    input  logic       ce2,
    input  logic       ce3_n,
    input  logic       gw_n,
    input  logic       bwe_n,
    input  lane_mask_t bsel_n,
    input  logic       sleep,
    output cmd_t       cmd,
    output logic       load,
    output logic       step,
    output logic       desel,
    output logic       asleep
);

    logic       active_q, rdmode_q;
    logic [1:0] slp_q;
    logic       cpu_go, ctl_go, start, chip_on, cont, start_sel, wants, do_wr, do_rd;
    lane_mask_t wmask;

    assign asleep = slp_q[1];

    always_comb begin
        cpu_go    = ~cpu_n & ~ce1_n;
        ctl_go    = ~cpu_go & ~ctl_n;
        start     = (cpu_go | ctl_go) & ~asleep;
        chip_on   = ~ce1_n & ce2 & ~ce3_n;
        start_sel = start & chip_on;
        cont      = ~start & active_q & ~asleep;
        wmask     = write_mask(gw_n, bwe_n, bsel_n);
        wants     = |wmask;
        do_wr     = (start_sel & ctl_go & wants) | (cont & wants);
        do_rd     = (start_sel & ~(ctl_go & wants)) | (cont & rdmode_q & ~wants);
        cmd.op    = do_wr ? OP_WRITE : (do_rd ? OP_READ : OP_IDLE);
        cmd.mask  = do_wr ? wmask : '0;
        load      = start_sel;
        step      = cont & ~adv_n;
        desel     = start & ~chip_on;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            rdmode_q <= 1'b0;
            slp_q    <= 2'b00;
        end else begin
            slp_q <= {slp_q[0], sleep};
            if (asleep) begin
                active_q <= 1'b0;
                rdmode_q <= 1'b0;
            end else if (start) begin
                active_q <= chip_on;
                rdmode_q <= start_sel & ~do_wr;
            end else if (do_wr) begin
                rdmode_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sram_burst.sv
module sram_burst
    import sram_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step_en,
    input  logic          linear,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] eff_addr
);

    logic [AW-3:0] hi_q;
    logic [1:0]    base_q, step_q;

    always_comb begin
        if (load)
            eff_addr = addr_in;
        else if (step_en)
            eff_addr = {hi_q, burst_low(linear, base_q, step_q + 2'd1)};
        else
            eff_addr = {hi_q, burst_low(linear, base_q, step_q)};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q   <= '0;
            base_q <= '0;
            step_q <= '0;
        end else if (load) begin
            hi_q   <= addr_in[AW-1:2];
            base_q <= addr_in[1:0];
            step_q <= '0;
        end else if (step_en) begin
            step_q <= step_q + 2'd1;
        end
    end

endmodule

// File: rtl/sram_array.sv
module sram_array
    import sram_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  cmd_t          cmd,
    input  logic [AW-1:0] addr,
    input  word_t         wdata,
    output word_t         rdata_s1
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (cmd.op == OP_WRITE && cmd.mask[l])
                mem[addr] <= wdata[l*LANE_W +: LANE_W];
            if (cmd.op == OP_READ)
                rd_q <= mem[addr];
        end

        assign rdata_s1[l*LANE_W +: LANE_W] = rd_q;
    end

endmodule

// File: rtl/sram_pipe.sv
module sram_pipe
    import sram_pkg::*;
#(
    parameter  int DEPTH = 256,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          cpu_n,
    input  logic          ctl_n,
    input  logic          adv_n,
    input  logic          ce1_n,
    input  logic          ce2,
    input  logic          ce3_n,
    input  logic          gw_n,
    input  logic          bwe_n,
    input  logic [3:0]    bsel_n,
    input  logic          oe_n,
    input  logic          sleep,
    input  logic          linear,
    input  logic [35:0]   wdata,
    output logic [35:0]   rdata,
    output logic          drive_en
);

    cmd_t          cmd;
    logic          load, step, desel, asleep;
    logic [AW-1:0] eff_addr;
    word_t         s1_data;
    logic          rd_go, wr_go, rd_v_s1, out_on_q;
    word_t         rdata_q;

    sram_ctrl u_ctrl (
        .clk(clk), .rst(rst), .cpu_n(cpu_n), .ctl_n(ctl_n), .adv_n(adv_n),
        .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .gw_n(gw_n), .bwe_n(bwe_n),
        .bsel_n(bsel_n), .sleep(sleep), .cmd(cmd), .load(load), .step(step),
        .desel(desel), .asleep(asleep)
    );

    sram_burst #(.AW(AW)) u_burst (
        .clk(clk), .rst(rst), .load(load), .step_en(step), .linear(linear),
        .addr_in(addr), .eff_addr(eff_addr)
    );

    sram_array #(.DEPTH(DEPTH), .AW(AW)) u_array (
        .clk(clk), .cmd(cmd), .addr(eff_addr), .wdata(wdata), .rdata_s1(s1_data)
    );

    assign rd_go = (cmd.op == OP_READ);
    assign wr_go = (cmd.op == OP_WRITE);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_v_s1  <= 1'b0;
            out_on_q <= 1'b0;
            rdata_q  <= '0;
        end else begin
            rd_v_s1  <= rd_go;
            out_on_q <= rd_v_s1 & ~wr_go & ~desel & ~asleep;
            if (rd_v_s1)
                rdata_q <= s1_data;
        end
    end

    assign rdata    = rdata_q;
    assign drive_en = out_on_q & ~oe_n & ~asleep;

endmodule

// File: rtl/sram_pipe_checker.sv
module sram_pipe_checker (
    input logic       clk,
    input logic       rst,
    input logic       cpu_n,
    input logic       ctl_n,
    input logic       ce1_n,
    input logic       ce2,
    input logic       ce3_n,
    input logic       gw_n,
    input logic       bwe_n,
    input logic [3:0] bsel_n,
    input logic       oe_n,
    input logic       sleep,
    input logic       drive_en,
    input logic       rd_go,
    input logic       wr_go
);

    logic chip_on, cpu_rec, strobe_rec, wr_req;
    assign chip_on    = ~ce1_n & ce2 & ~ce3_n;
    assign cpu_rec    = ~cpu_n & ~ce1_n;
    assign strobe_rec = cpu_rec | ~ctl_n;
    assign wr_req     = ~gw_n | (~bwe_n & (bsel_n != 4'hF));

    assert_oe_gate_R8: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !drive_en);

    assert_desel_off_R10: assert property (@(posedge clk) disable iff (rst)
        (strobe_rec && !chip_on) |=> !drive_en);

    assert_cpu_start_read_R3: assert property (@(posedge clk) disable iff (rst)
        cpu_rec |-> !wr_go);

    assert_ctl_write_R4: assert property (@(posedge clk) disable iff (rst)
        (!cpu_rec && !ctl_n && chip_on && wr_req && !$past(sleep, 2)) |-> wr_go);

    assert_write_off_R9: assert property (@(posedge clk) disable iff (rst)
        wr_go |=> !drive_en);

    assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
        drive_en |-> $past(rd_go, 2));

    assert_sleep_off_R11: assert property (@(posedge clk) disable iff (rst)
        $past(sleep, 2) |-> !drive_en);

endmodule

bind sram_pipe sram_pipe_checker u_chk (
    .clk(clk), .rst(rst), .cpu_n(cpu_n), .ctl_n(ctl_n), .ce1_n(ce1_n),
    .ce2(ce2), .ce3_n(ce3_n), .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n),
    .oe_n(oe_n), .sleep(sleep), .drive_en(drive_en), .rd_go(rd_go), .wr_go(wr_go)
);

// File: tb/sram_pipe_bench.sv
module sram_pipe_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  addr;
    logic        cpu_n, ctl_n, adv_n, ce1_n, ce2, ce3_n, gw_n, bwe_n, oe_n, sleep, linear;
    logic [3:0]  bsel_n;
    logic [35:0] wdata;
    logic [35:0] rdata;
    logic        drive_en;

    logic [35:0] shadow [256];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sram_pipe u_sram_pipe (
        .clk(clk), .rst(rst), .addr(addr), .cpu_n(cpu_n), .ctl_n(ctl_n),
        .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .gw_n(gw_n),
        .bwe_n(bwe_n), .bsel_n(bsel_n), .oe_n(oe_n), .sleep(sleep),
        .linear(linear), .wdata(wdata), .rdata(rdata), .drive_en(drive_en)
    );

    function automatic logic [35:0] merge(logic [35:0] old, logic [35:0] d,
                                          logic all_n, logic byte_n, logic [3:0] sel_n);
        logic [35:0] r = old;
        for (int l = 0; l < 4; l++)
            if (!all_n || (!byte_n && !sel_n[l]))
                r[l*9 +: 9] = d[l*9 +: 9];
        return r;
    endfunction

    task automatic chk(bit ok, string req, logic [35:0] act, logic [35:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        cpu_n = 1; ctl_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1; bsel_n = 4'hF;
    endtask

    task automatic sel_on();
        ce1_n = 0; ce2 = 1; ce3_n = 0;
    endtask

    task automatic ctl_write(logic [7:0] a, logic [35:0] d, logic all_n,
                             logic byte_n, logic [3:0] sel_n, logic adv);
        sel_on(); ctl_n = 0; addr = a; wdata = d;
        gw_n = all_n; bwe_n = byte_n; bsel_n = sel_n; adv_n = adv;
        tick();
        idle();
        shadow[a] = merge(shadow[a], d, all_n, byte_n, sel_n);
    endtask

    task automatic cpu_write(logic [7:0] a, logic [35:0] d, logic all_n,
                             logic byte_n, logic [3:0] sel_n);
        sel_on(); cpu_n = 0; addr = a; wdata = ~d;
        gw_n = 0; bwe_n = 0; bsel_n = 4'h0; adv_n = 0;
        tick();
        cpu_n = 1; adv_n = 1; wdata = d; gw_n = all_n; bwe_n = byte_n; bsel_n = sel_n;
        tick();
        idle();
        shadow[a] = merge(shadow[a], d, all_n, byte_n, sel_n);
    endtask

    task automatic read_chk(logic [7:0] a, string req);
        sel_on(); cpu_n = 0; addr = a; oe_n = 0;
        tick();
        idle();
        tick();
        chk(drive_en === 1'b1 && rdata === shadow[a], req, rdata, shadow[a]);
    endtask

    task automatic deselect();
        ce1_n = 0; ce2 = 0; ce3_n = 0; ctl_n = 0;
        tick();
        idle(); sel_on();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] r;
        logic [7:0]  a;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) shadow[i] = 36'h0;
        rst = 1; idle(); sel_on(); oe_n = 0; sleep = 0; linear = 1; addr = 0; wdata = 0;
        tick(); tick();
        rst = 0;
        chk(drive_en === 1'b0, "R8 reset drive", {35'd0, drive_en}, 36'd0);

        // Preload burst region and test words
        for (int i = 0; i < 8; i++) ctl_write(8'h40 + 8'(i), 36'h111111111 * 36'(i + 1), 0, 1, 4'hF, 1);
        ctl_write(8'h10, 36'hABCDEF012, 0, 1, 4'hF, 1);
        ctl_write(8'h11, 36'h123456789, 0, 1, 4'hF, 1);

        // R8 first-cycle mask from deselected, R6 latency
        deselect();
        cpu_n = 0; addr = 8'h10; oe_n = 0;
        tick(); idle();
        chk(drive_en === 1'b0, "R8 first cycle masked", {35'd0, drive_en}, 36'd0);
        tick();
        chk(drive_en === 1'b1 && rdata === shadow[8'h10], "R6 read after second edge", rdata, shadow[8'h10]);
        // back-to-back: new start keeps old data one more cycle
        cpu_n = 0; addr = 8'h11;
        tick(); idle();
        chk(rdata === shadow[8'h10], "R6 pipeline holds previous", rdata, shadow[8'h10]);
        tick();
        chk(rdata === shadow[8'h11], "R6 next read", rdata, shadow[8'h11]);
        // R8 output enable
        oe_n = 1; #1;
        chk(drive_en === 1'b0, "R8 oe high", {35'd0, drive_en}, 36'd0);
        oe_n = 0;

        // R1 chip enables not sampled while continuing
        ce2 = 0; tick();
        chk(drive_en === 1'b1 && rdata === shadow[8'h11], "R1 continue ignores enables", rdata, shadow[8'h11]);
        sel_on();
        // R1 each disabling enable deselects on a strobe
        for (int v = 0; v < 3; v++) begin
            read_chk(8'h10, "R1 select");
            ce1_n = (v == 0); ce2 = (v != 1); ce3_n = (v == 2); ctl_n = 0;
            tick(); idle(); sel_on();
            chk(drive_en === 1'b0, "R10 R1 deselect turns off", {35'd0, drive_en}, 36'd0);
        end

        // R2 processor strobe ignored when ce1_n high
        read_chk(8'h10, "R2 setup");
        ce1_n = 1; cpu_n = 0; addr = 8'h11;
        tick(); idle(); sel_on();
        tick();
        chk(drive_en === 1'b1 && rdata === shadow[8'h10], "R2 cpu ignored", rdata, shadow[8'h10]);
        // R2 priority: both strobes, write inputs active -> read, no write
        cpu_n = 0; ctl_n = 0; addr = 8'h12; wdata = 36'hFFFFFFFFF; gw_n = 0;
        tick(); idle();
        tick();
        chk(drive_en === 1'b1 && rdata === shadow[8'h12], "R2 priority read no write", rdata, shadow[8'h12]);
        read_chk(8'h12, "R2 memory unchanged");

        // R3 processor write lands on second edge
        cpu_write(8'h20, 36'h9A5A5A5A5, 0, 1, 4'hF);
        read_chk(8'h20, "R3 second edge write");
        cpu_write(8'h21, 36'h0F0F0F0F0, 1, 0, 4'b1010);
        read_chk(8'h21, "R5 R3 lane write");

        // R4 controller write on same edge ignores adv; continue write advances
        linear = 1;
        ctl_write(8'h50, 36'h050505050, 0, 1, 4'hF, 0);
        wdata = 36'h151515151; gw_n = 0; adv_n = 0;
        tick(); idle();
        shadow[8'h51] = 36'h151515151;
        read_chk(8'h50, "R4 write at loaded address");
        read_chk(8'h51, "R4 continue write advanced");

        // R9 drive off after write until new read
        ctl_write(8'h30, 36'h333333333, 0, 1, 4'hF, 1);
        for (int k = 0; k < 3; k++) begin
            oe_n = 0; tick();
            chk(drive_en === 1'b0, "R9 off after write", {35'd0, drive_en}, 36'd0);
        end
        read_chk(8'h30, "R9 read restores drive");

        // R5 directed lane merge
        ctl_write(8'h31, 36'h3FFFFFFFF, 1, 0, 4'b0110, 1);
        read_chk(8'h31, "R5 lanes 0 and 3 written");
        ctl_write(8'h31, 36'h000000000, 1, 1, 4'h0, 1);
        read_chk(8'h31, "R5 no write without enable");

        // R7 linear burst from 0x42: 42 43 40 41
        linear = 1;
        sel_on(); cpu_n = 0; addr = 8'h42; tick(); idle(); adv_n = 0;
        tick(); chk(rdata === shadow[8'h42], "R7 linear step0", rdata, shadow[8'h42]);
        tick(); chk(rdata === shadow[8'h43], "R7 linear step1", rdata, shadow[8'h43]);
        tick(); chk(rdata === shadow[8'h40], "R7 linear wrap", rdata, shadow[8'h40]);
        adv_n = 1;
        tick(); chk(rdata === shadow[8'h41], "R7 linear step3", rdata, shadow[8'h41]);
        // R7 interleaved from 0x45: 45 44 47 46
        linear = 0;
        cpu_n = 0; addr = 8'h45; tick(); idle(); adv_n = 0;
        tick(); chk(rdata === shadow[8'h45], "R7 interleaved step0", rdata, shadow[8'h45]);
        tick(); chk(rdata === shadow[8'h44], "R7 interleaved step1", rdata, shadow[8'h44]);
        tick(); chk(rdata === shadow[8'h47], "R7 interleaved step2", rdata, shadow[8'h47]);
        adv_n = 1;
        tick(); chk(rdata === shadow[8'h46], "R7 interleaved step3", rdata, shadow[8'h46]);
        linear = 1;

        // R11 sleep
        deselect();
        sleep = 1; tick(); tick(); tick();
        sel_on(); ctl_n = 0; addr = 8'h30; wdata = 36'h0DEADBEEF; gw_n = 0;
        tick(); idle();
        cpu_n = 0; addr = 8'h30; tick(); idle();
        chk(drive_en === 1'b0, "R11 off in sleep", {35'd0, drive_en}, 36'd0);
        sleep = 0; tick(); tick();
        chk(drive_en === 1'b0, "R11 off after exit", {35'd0, drive_en}, 36'd0);
        read_chk(8'h30, "R11 contents kept");

        // Random mix of writes and reads
        for (int it = 0; it < 150; it++) begin
            r = {$urandom(), $urandom()};
            a = 8'($urandom());
            case ($urandom() % 3)
                0: ctl_write(a, r[35:0], 0, 1, 4'($urandom()), 1'($urandom()));
                1: ctl_write(a, r[35:0], 1, 1'($urandom()), 4'($urandom()), 1'($urandom()));
                default: cpu_write(a, r[35:0], 1'($urandom()), 1'($urandom()), 4'($urandom()));
            endcase
            if ($urandom() % 2) read_chk(a, "R5 random lane write");
            else read_chk(8'($urandom()), "R5 random read");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule